// File: doc/BRIEF.md
# PLL Configuration Decoder

This block works out the pixel clock that a frequency synthesizer is producing from the two configuration words that software reads back from it. It unpacks the post-divider, pre-divider and feedback code, turns the feedback code back into its integer multiplier with a small code table, and then runs two integer divisions. The first gives the serial link clock as floor(M*ref/(P*N)). The second scales that clock by the lane count and divides it by the bits per pixel, rounding to nearest. A pulse on `start` begins one decode. A one-cycle `done` pulse ends it. The result and flags then hold until the next `start`.

The controller is a state machine with six states. IDLE waits for `start` and captures the operands. UNPACK decodes P and checks it. SEEK walks the code table one entry per cycle, from the highest index down. DIVCLK runs the clock division. DIVPIX runs the rounded pixel division. FINISH raises `done`. The transitions are:
- IDLE->UNPACK on start.
- UNPACK->FINISH on a zero P, otherwise UNPACK->SEEK.
- SEEK->DIVCLK on a code match.
- SEEK->FINISH when index 0 misses.
- DIVCLK->DIVPIX and DIVPIX->FINISH on the divider's completion pulse.
- FINISH->IDLE unconditionally.

Top module: `pllcfg_decoder`

## Requirements
- R1: The reference frequency is 25000 kHz when `plat_sel` is 0 and 100000 kHz when `plat_sel` is 1.
- R2: N equals 1 shifted left by the two-bit field `div_word[17:16]`, so N is one of 1, 2, 4 or 8.
- R3: P is 2 plus the position of the highest set bit of the five-bit field `ctrl_word[12:8]`, giving 2 to 6. A zero field decodes to P = 0. P = 0 raises `err_post`, and the result is zero.
- R4: The feedback code is `div_word[8:0]`. M is 62 plus the index of the table entry equal to that code. The table, from index 0 to 38, is: 426 469 234 373 442 221 110 311 411 461 486 243 377 188 350 175 343 427 213 106 53 282 397 454 227 113 56 284 142 71 35 273 136 324 418 465 488 500 506. A code found nowhere in the table raises `err_seed`, and the result is zero.
- R5: The serial clock in kHz is floor(M*ref/(P*N)).
- R6: `pclk_khz` equals (clk*lanes + bpp/2)/bpp in unsigned integer arithmetic.
- R7: Every `start` accepted in IDLE produces exactly one `done` pulse of one cycle. A successful decode sets `valid` before `done` rises. No more than one error flag is ever high.
- R8: When either error flag is set, `pclk_khz` is zero and `valid` is low. A bad P takes priority over a bad feedback code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode; sampled only in IDLE |
| ctrl_word | input | 32 | Control word holding the post-divider field |
| div_word | input | 32 | Divider word holding the N exponent and feedback code |
| plat_sel | input | 1 | Selects the reference frequency |
| lanes | input | 3 | Number of data lanes, 1 to 4 |
| bpp | input | 5 | Bits per pixel: 16, 18 or 24 |
| done | output | 1 | One-cycle completion pulse |
| pclk_khz | output | 32 | Decoded pixel clock in kHz |
| valid | output | 1 | Result is a successful decode |
| err_post | output | 1 | Post-divider field decoded to zero |
| err_seed | output | 1 | Feedback code not found in the table |

## Verification
The assertions assume the following about the inputs:
- `bpp` is nonzero.
- `lanes` is at most 4, so the pixel-division numerator cannot overflow.
- `start` is pulsed only while the block is idle. The divider's floor check assumes it is never restarted mid-run.

The stimulus respects all of this. It uses only bpp values of 16, 18 and 24 and lane counts of 1 to 4. It waits for each `done` before issuing the next `start`. Expected results come from a separate model of the table and arithmetic, and a scoreboard queue holds them in order.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int SEED_COUNT = 39;
    localparam int M_BASE     = 62;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNPACK,
        ST_SEEK,
        ST_DIVCLK,
        ST_DIVPIX,
        ST_FINISH
    } dec_state_t;

    // Feedback-code table: entry i encodes multiplier M_BASE + i.
    function automatic logic [8:0] seed_code(input logic [5:0] i);
        logic [8:0] c;
        case (i)
            6'd0:  c = 9'd426;  6'd1:  c = 9'd469;  6'd2:  c = 9'd234;
            6'd3:  c = 9'd373;  6'd4:  c = 9'd442;  6'd5:  c = 9'd221;
            6'd6:  c = 9'd110;  6'd7:  c = 9'd311;  6'd8:  c = 9'd411;
            6'd9:  c = 9'd461;  6'd10: c = 9'd486;  6'd11: c = 9'd243;
            6'd12: c = 9'd377;  6'd13: c = 9'd188;  6'd14: c = 9'd350;
            6'd15: c = 9'd175;  6'd16: c = 9'd343;  6'd17: c = 9'd427;
            6'd18: c = 9'd213;  6'd19: c = 9'd106;  6'd20: c = 9'd53;
            6'd21: c = 9'd282;  6'd22: c = 9'd397;  6'd23: c = 9'd454;
            6'd24: c = 9'd227;  6'd25: c = 9'd113;  6'd26: c = 9'd56;
            6'd27: c = 9'd284;  6'd28: c = 9'd142;  6'd29: c = 9'd71;
            6'd30: c = 9'd35;   6'd31: c = 9'd273;  6'd32: c = 9'd136;
            6'd33: c = 9'd324;  6'd34: c = 9'd418;  6'd35: c = 9'd465;
            6'd36: c = 9'd488;  6'd37: c = 9'd500;  6'd38: c = 9'd506;
            default: c = 9'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pllcfg_seed_rom.sv
module pllcfg_seed_rom
    import pllcfg_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int CODE_W = 9
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = CODE_W'(seed_code(6'(idx)));
    end
endmodule

// File: rtl/pllcfg_divider.sv
module pllcfg_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, num_l, den_l;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [W:0]    trial;

    assign trial = {rem_q, quo[W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo    <= '0;
            num_l  <= '0;
            den_l  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else if (go) begin
            rem_q  <= '0;
            quo    <= num;
            num_l  <= num;
            den_l  <= den;
            cnt_q  <= CW'(W);
            busy_q <= 1'b1;
            done   <= 1'b0;
        end else if (busy_q) begin
            if (trial >= {1'b0, den_l}) begin
                rem_q <= W'(trial - {1'b0, den_l});
                quo   <= {quo[W-2:0], 1'b1};
            end else begin
                rem_q <= trial[W-1:0];
                quo   <= {quo[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R5: the quotient is the floor of num/den.
    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_l != '0) |->
            (({{W{1'b0}}, quo} * {{W{1'b0}}, den_l}) <= {{W{1'b0}}, num_l}) &&
            (({{W{1'b0}}, quo} * {{W{1'b0}}, den_l} + {{W{1'b0}}, den_l}) > {{W{1'b0}}, num_l}));

    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pllcfg_decoder.sv
module pllcfg_decoder
    import pllcfg_pkg::*;
#(
    parameter int W        = 32,
    parameter int POST_LSB = 8,
    parameter int POST_W   = 5,
    parameter int NLOG_LSB = 16,
    parameter int NLOG_W   = 2,
    parameter int SEED_LSB = 0,
    parameter int SEED_W   = 9,
    parameter int REF0_KHZ = 25000,
    parameter int REF1_KHZ = 100000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [31:0]  ctrl_word,
    input  logic [31:0]  div_word,
    input  logic         plat_sel,
    input  logic [2:0]   lanes,
    input  logic [4:0]   bpp,
    output logic         done,
    output logic [31:0]  pclk_khz,
    output logic         valid,
    output logic         err_post,
    output logic         err_seed
);
    localparam int IDX_W = $clog2(SEED_COUNT);
    localparam int PV_W  = $clog2(POST_W + 2) + 1;

    dec_state_t st_q, st_d;

    logic [POST_W-1:0] post_q;
    logic [NLOG_W-1:0] nlog_q;
    logic [SEED_W-1:0] code_q;
    logic              ref_sel_q;
    logic [2:0]        lanes_q;
    logic [4:0]        bpp_q;
    logic [PV_W-1:0]   p_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SEED_W-1:0] rom_code;
    logic              dv_go, dv_done;
    logic [W-1:0]      dv_num, dv_den, dv_quo;
    logic [W-1:0]      ref_w;
    logic [PV_W-1:0]   p_dec;

    // P = 2 + index of highest set bit; empty field gives zero.
    function automatic logic [PV_W-1:0] post_decode(input logic [POST_W-1:0] f);
        logic [PV_W-1:0] r;
        r = '0;
        for (int k = 0; k < POST_W; k++) begin
            if (f[k]) r = PV_W'(k + 2);
        end
        return r;
    endfunction

    assign p_dec = post_decode(post_q);
    assign ref_w = ref_sel_q ? W'(REF1_KHZ) : W'(REF0_KHZ);

    pllcfg_seed_rom #(.IDX_W(IDX_W), .CODE_W(SEED_W)) u_rom (
        .idx  (idx_q),
        .code (rom_code)
    );

    pllcfg_divider #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (dv_go),
        .num   (dv_num),
        .den   (dv_den),
        .done  (dv_done),
        .quo   (dv_quo)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_UNPACK;
            ST_UNPACK: st_d = (p_dec == '0) ? ST_FINISH : ST_SEEK;
            ST_SEEK: begin
                if (rom_code == code_q)   st_d = ST_DIVCLK;
                else if (idx_q == '0)     st_d = ST_FINISH;
            end
            ST_DIVCLK: if (dv_done) st_d = ST_DIVPIX;
            ST_DIVPIX: if (dv_done) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_q    <= '0;
            nlog_q    <= '0;
            code_q    <= '0;
            ref_sel_q <= 1'b0;
            lanes_q   <= '0;
            bpp_q     <= '0;
            p_q       <= '0;
            idx_q     <= '0;
            dv_go     <= 1'b0;
            dv_num    <= '0;
            dv_den    <= '0;
            done      <= 1'b0;
            pclk_khz  <= '0;
            valid     <= 1'b0;
            err_post  <= 1'b0;
            err_seed  <= 1'b0;
        end else begin
            dv_go <= 1'b0;
            done  <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    post_q    <= ctrl_word[POST_LSB +: POST_W];
                    nlog_q    <= div_word[NLOG_LSB +: NLOG_W];
                    code_q    <= div_word[SEED_LSB +: SEED_W];
                    ref_sel_q <= plat_sel;
                    lanes_q   <= lanes;
                    bpp_q     <= bpp;
                    pclk_khz  <= '0;
                    valid     <= 1'b0;
                    err_post  <= 1'b0;
                    err_seed  <= 1'b0;
                end
                ST_UNPACK: begin
                    p_q   <= p_dec;
                    idx_q <= IDX_W'(SEED_COUNT - 1);
                    if (p_dec == '0) err_post <= 1'b1;
                end
                ST_SEEK: begin
                    if (rom_code == code_q) begin
                        dv_num <= (W'(idx_q) + W'(M_BASE)) * ref_w;
                        dv_den <= W'(p_q) << nlog_q;
                        dv_go  <= 1'b1;
                    end else if (idx_q == '0) begin
                        err_seed <= 1'b1;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                ST_DIVCLK: if (dv_done) begin
                    dv_num <= dv_quo * W'(lanes_q) + W'(bpp_q >> 1);
                    dv_den <= W'(bpp_q);
                    dv_go  <= 1'b1;
                end
                ST_DIVPIX: if (dv_done) begin
                    pclk_khz <= dv_quo;
                    valid    <= 1'b1;
                end
                ST_FINISH: done <= 1'b1;
                default: ;
            endcase
        end
    end

    p_one_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_post && err_seed));

    p_fail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_post || err_seed) |-> (pclk_khz == '0 && !valid));

    p_valid_then_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |=> done);

    p_post_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_post) |-> (post_q == '0));
endmodule

// File: tb/sim_pllcfg_decoder.sv
module sim_pllcfg_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] div_word = '0;
    logic        plat_sel = 1'b0;
    logic [2:0]  lanes = 3'd1;
    logic [4:0]  bpp = 5'd24;
    logic        done;
    logic [31:0] pclk_khz;
    logic        valid, err_post, err_seed;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] pclk;
        logic        vld;
        logic        ep;
        logic        es;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pllcfg_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ctrl_word(ctrl_word), .div_word(div_word), .plat_sel(plat_sel),
        .lanes(lanes), .bpp(bpp), .done(done), .pclk_khz(pclk_khz),
        .valid(valid), .err_post(err_post), .err_seed(err_seed)
    );

    function automatic int tb_code(input int i);
        int t[39] = '{426, 469, 234, 373, 442, 221, 110, 311, 411, 461, 486,
                      243, 377, 188, 350, 175, 343, 427, 213, 106, 53, 282,
                      397, 454, 227, 113, 56, 284, 142, 71, 35, 273, 136, 324,
                      418, 465, 488, 500, 506};
        return t[i];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: model the expected result, queue it, start the decode, wait for done.
    task automatic run_op(input string req, input bit plat, input logic [4:0] post,
                          input logic [1:0] nlog, input int code,
                          input int ln, input int bp);
        exp_t e;
        int p = 0;
        int m = -1;
        longint clkv;
        for (int k = 0; k < 5; k++) if (post[k]) p = k + 2;
        for (int i = 0; i < 39; i++) if (tb_code(i) == code && m < 0) m = i + 62;
        e.req = req;
        e.ep = 0; e.es = 0; e.vld = 0; e.pclk = 0;
        if (p == 0) e.ep = 1;
        else if (m < 0) e.es = 1;
        else begin
            clkv = (longint'(m) * (plat ? 100000 : 25000)) / (p * (1 << nlog));
            e.pclk = 32'((clkv * ln + bp / 2) / bp);
            e.vld = 1;
        end
        sb.push_back(e);
        @(negedge clk);
        ctrl_word = 32'h0000_0000 | (32'(post) << 8) | 32'h8000_0001;
        div_word  = (32'(nlog) << 16) | 32'(code[8:0]) | 32'h0100_0000;
        plat_sel = plat;
        lanes = 3'(ln);
        bpp = 5'(bp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare on every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check("R7", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "pclk_khz", pclk_khz, e.pclk);
                check(e.req, "valid", 32'(valid), 32'(e.vld));
                check(e.req, "err_post", 32'(err_post), 32'(e.ep));
                check(e.req, "err_seed", 32'(err_seed), 32'(e.es));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "reset done", 32'(done), 0);
        check("R8", "reset pclk", pclk_khz, 0);
        check("R7", "reset valid", 32'(valid), 0);
        check("R7", "reset errors", 32'({err_post, err_seed}), 0);

        run_op("R1 R5 R6 low ref first entry", 0, 5'b00001, 2'd0, 426, 4, 24);
        run_op("R1 R2 R5 high ref last entry", 1, 5'b10000, 2'd2, 506, 3, 18);
        run_op("R3 multi-bit post field", 0, 5'b01011, 2'd1, 106, 2, 16);
        run_op("R2 N of eight", 1, 5'b00100, 2'd3, 282, 1, 24);
        run_op("R3 zero post field", 0, 5'b00000, 2'd0, 426, 4, 24);
        run_op("R4 unknown code", 1, 5'b00010, 2'd0, 0, 4, 24);
        run_op("R8 both faults post wins", 0, 5'b00000, 2'd0, 1, 2, 18);
        run_op("R4 R5 mid-table entry", 0, 5'b00010, 2'd0, 53, 3, 24);
        for (int i = 0; i < 8; i++) begin
            run_op("R6 rounding sweep", i[0], 5'(1 << (i % 5)), 2'(i % 4),
                   tb_code(i * 5), (i % 4) + 1, (i % 3 == 0) ? 16 : ((i % 3 == 1) ? 18 : 24));
        end
        run_op("R7 recovery after error", 0, 5'b00001, 2'd0, 500, 4, 24);
        check("R7", "scoreboard drained", 32'(sb.size()), 0);
        finish_run();
    end
endmodule